// File: doc/BRIEF.md
# Host Command Message Decoder

The decoder sits between a host controller and a signal-processing core. The host writes 16-bit words one at a time into an input port. The block groups these words into command messages. Each message begins with a header word and a debug tag word. Memory-download commands run inside the block. Each one loads a memory-configuration register, emits a burst of data-RAM writes on a write port, and then loads the configuration register a second time. Procedure-execute, packet, reset and no-op commands go to the core as a stream of payload strobes, followed by a completion pulse that carries the opcode and tag.

In the other direction, the core posts procedure results as return values and then a commit. Errors in the command stream are also reported this way. The block builds each of these into an indication message. The host reads that message word by word from an output port. Only one indication is held at a time. A second indication waits until the host has read every word of the first one.

Top module: `hostmsg_decoder`

## Requirements
- R1: After reset, `in_ready` and `ret_ready` are 1, `out_valid`, `ram_we`, `cmd_word_valid` and `cmd_done` are 0, and `mc_cfg` is 0.
- R2: A message's first word carries the opcode in bits 15:8 and the total word count in bits 7:0. Its second word is a tag. When a forwarded command completes, `cmd_op` and `cmd_id` present that opcode and tag.
- R3: For a download (opcode 0x00), `mc_cfg` takes the first payload word in the cycle after that word is accepted. It holds that value during every data write of the download.
- R4: A download's data writes follow the word count given in its second payload word, and the length byte is ignored. Each write appears on `ram_we`/`ram_addr`/`ram_wdata` in the cycle after its data word is accepted. The first write goes to the start address given in the third payload word, and each later write goes one address higher.
- R5: A download's final word is loaded into `mc_cfg` in the cycle after it is accepted, and no further RAM write follows it.
- R6: A download with a word count of zero issues no RAM write. It still loads `mc_cfg` with the first value and then with the final value.
- R7: Opcodes 0x01, 0x02, 0x03 and 0x05 forward their length−2 words after the tag. Each word appears on `cmd_word_valid`/`cmd_word` in the cycle after it is accepted. `cmd_done` pulses together with the last forwarded word, or in the cycle after the tag when the length is 2.
- R8: An opcode outside {0x00, 0x01, 0x02, 0x03, 0x05} ends the message once its tag is accepted. The block then queues the error indication 0x1203, tag, 0x0001. The next word it accepts is parsed as a new header.
- R9: A length below the minimum for the opcode queues the error indication 0x1203, tag, 0x0002 and ends the message. The minimums are 3 for 0x01 and 0x03, and 2 for 0x02 and 0x05.
- R10: `ret_commit` produces the indication header {0x11, 3+k}, followed by `ret_id`, `ret_proc` and the k values pushed with `ret_push` in push order. It appears on `out_valid`/`out_data` in the cycle after the commit.
- R11: An indication word stays on `out_data` until the host pulses `out_read`. While an indication is unread, `ret_ready` is 0 and pushes are ignored. A pending parser error keeps `in_ready` at 0 until the output port is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Host presents a word |
| in_data | input | 16 | Host word |
| in_ready | output | 1 | Word taken when high with in_valid |
| out_valid | output | 1 | Indication word available |
| out_data | output | 16 | Current indication word |
| out_read | input | 1 | Host consumes the current word |
| ram_we | output | 1 | Data RAM write strobe |
| ram_addr | output | AW | Data RAM write address |
| ram_wdata | output | 16 | Data RAM write data |
| mc_cfg | output | MCW | Memory-configuration register |
| cmd_op | output | 8 | Opcode of forwarded command |
| cmd_id | output | 16 | Tag of forwarded command |
| cmd_word_valid | output | 1 | Payload word strobe |
| cmd_word | output | 16 | Payload word |
| cmd_done | output | 1 | Forwarded command complete |
| ret_push | input | 1 | Core appends a return value |
| ret_word | input | 16 | Return value |
| ret_commit | input | 1 | Core closes the return indication |
| ret_proc | input | 16 | Procedure number for the indication |
| ret_id | input | 16 | Tag echoed in the indication |
| ret_ready | output | 1 | Core may push or commit |

## Verification
Every result that comes from a host word appears exactly one clock after the edge that accepts the word. This covers configuration loads, RAM writes, payload strobes and the completion pulse. Each write task drives at the falling edge, lets one rising edge pass, and checks these outputs at the next falling edge. An error indication becomes readable one cycle after the tag is accepted, provided the output port is idle. A return indication becomes readable one cycle after its commit. Reads check `out_data` at a falling edge before pulsing `out_read`, and hold-off checks wait several cycles so that a word that changed too early would be caught.

// File: rtl/hostmsg_pkg.sv
package hostmsg_pkg;
  localparam logic [7:0] OP_DNLD = 8'h00;
  localparam logic [7:0] OP_EXEC = 8'h01;
  localparam logic [7:0] OP_PKT  = 8'h02;
  localparam logic [7:0] OP_RST  = 8'h03;
  localparam logic [7:0] OP_NOP  = 8'h05;
  localparam logic [7:0] OP_RET  = 8'h11;
  localparam logic [7:0] OP_ERR  = 8'h12;

  localparam logic [15:0] ERR_OPCODE = 16'h0001;
  localparam logic [15:0] ERR_LENGTH = 16'h0002;

  typedef enum logic [3:0] {
    PS_HDR, PS_ID, PS_PAY, PS_MCB, PS_NW, PS_ADR, PS_DAT, PS_MCA, PS_ERR
  } pstate_t;

  function automatic logic op_known(input logic [7:0] op);
    return (op == OP_DNLD) || (op == OP_EXEC) || (op == OP_PKT) ||
           (op == OP_RST)  || (op == OP_NOP);
  endfunction

  function automatic logic [7:0] op_min_len(input logic [7:0] op);
    case (op)
      OP_EXEC, OP_RST: return 8'd3;
      OP_PKT, OP_NOP:  return 8'd2;
      default:         return 8'd0;
    endcase
  endfunction

  function automatic logic [15:0] ind_hdr(input logic [7:0] op, input logic [7:0] len);
    return {op, len};
  endfunction
endpackage

// File: rtl/hostmsg_parser.sv
module hostmsg_parser
  import hostmsg_pkg::*;
#(
  parameter int AW  = 10,
  parameter int MCW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [15:0]    in_data,
  output logic           in_ready,
  output logic           ram_we,
  output logic [AW-1:0]  ram_addr,
  output logic [15:0]    ram_wdata,
  output logic [MCW-1:0] mc_cfg,
  output logic [7:0]     cmd_op,
  output logic [15:0]    cmd_id,
  output logic           cmd_word_valid,
  output logic [15:0]    cmd_word,
  output logic           cmd_done,
  output logic           err_valid,
  output logic [15:0]    err_id,
  output logic [15:0]    err_code,
  input  logic           err_ack
);
  pstate_t       st;
  logic [7:0]    op_q, len_q;
  logic [15:0]   id_q, cnt;
  logic [AW-1:0] addr_q;
  logic          acc;

  assign acc       = in_valid && in_ready;
  assign in_ready  = (st != PS_ERR);
  assign err_valid = (st == PS_ERR);
  assign err_id    = id_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= PS_HDR; op_q <= '0; len_q <= '0; id_q <= '0; cnt <= '0;
      addr_q <= '0; ram_we <= 1'b0; ram_addr <= '0; ram_wdata <= '0;
      mc_cfg <= '0; cmd_op <= '0; cmd_id <= '0; cmd_word_valid <= 1'b0;
      cmd_word <= '0; cmd_done <= 1'b0; err_code <= '0;
    end else begin
      ram_we         <= 1'b0;
      cmd_word_valid <= 1'b0;
      cmd_done       <= 1'b0;
      case (st)
        PS_HDR: if (acc) begin
          op_q  <= in_data[15:8];
          len_q <= in_data[7:0];
          st    <= PS_ID;
        end
        PS_ID: if (acc) begin
          id_q <= in_data;
          if (op_q == OP_DNLD) st <= PS_MCB;
          else if (!op_known(op_q)) begin
            err_code <= ERR_OPCODE; st <= PS_ERR;
          end else if (len_q < op_min_len(op_q)) begin
            err_code <= ERR_LENGTH; st <= PS_ERR;
          end else begin
            cmd_op <= op_q;
            cmd_id <= in_data;
            cnt    <= {8'd0, len_q} - 16'd2;
            if (len_q == 8'd2) begin
              cmd_done <= 1'b1; st <= PS_HDR;
            end else st <= PS_PAY;
          end
        end
        PS_PAY: if (acc) begin
          cmd_word_valid <= 1'b1;
          cmd_word       <= in_data;
          cnt            <= cnt - 16'd1;
          if (cnt == 16'd1) begin
            cmd_done <= 1'b1; st <= PS_HDR;
          end
        end
        PS_MCB: if (acc) begin
          mc_cfg <= in_data[MCW-1:0]; st <= PS_NW;
        end
        PS_NW: if (acc) begin
          cnt <= in_data; st <= PS_ADR;
        end
        PS_ADR: if (acc) begin
          addr_q <= in_data[AW-1:0];
          st     <= (cnt == 16'd0) ? PS_MCA : PS_DAT;
        end
        PS_DAT: if (acc) begin
          ram_we    <= 1'b1;
          ram_addr  <= addr_q;
          ram_wdata <= in_data;
          addr_q    <= addr_q + AW'(1);
          cnt       <= cnt - 16'd1;
          if (cnt == 16'd1) st <= PS_MCA;
        end
        PS_MCA: if (acc) begin
          mc_cfg <= in_data[MCW-1:0]; st <= PS_HDR;
        end
        PS_ERR: if (err_ack) st <= PS_HDR;
        default: st <= PS_HDR;
      endcase
    end
  end

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we && $past(ram_we) |-> ram_addr == $past(ram_addr) + AW'(1)); // R4
  AST_MC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we && $past(ram_we) |-> $stable(mc_cfg)); // R3
  AST_WE_CMD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_we && (cmd_word_valid || cmd_done))); // R7
endmodule

// File: rtl/hostmsg_ind.sv
module hostmsg_ind
  import hostmsg_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ret_push,
  input  logic [15:0] ret_word,
  input  logic        ret_commit,
  input  logic [15:0] ret_proc,
  input  logic [15:0] ret_id,
  output logic        ret_ready,
  input  logic        err_valid,
  input  logic [15:0] err_id,
  input  logic [15:0] err_code,
  output logic        err_ack,
  output logic        out_valid,
  output logic [15:0] out_data,
  input  logic        out_read
);
  localparam int PW   = $clog2(DEPTH);
  localparam int LW   = $clog2(DEPTH + 1);
  localparam int VMAX = DEPTH - 3;

  logic [15:0]   buf_q [DEPTH];
  logic          draining;
  logic [PW-1:0] rd_ptr;
  logic [LW-1:0] len_q, fill;
  logic [PW-1:0] wr_idx;
  logic          do_commit, do_push, last_rd;

  assign ret_ready = !draining;
  assign err_ack   = err_valid && !draining && (fill == '0) && !ret_push && !ret_commit;
  assign out_valid = draining;
  assign out_data  = buf_q[rd_ptr];
  assign wr_idx    = PW'(fill + LW'(3));
  assign do_commit = !draining && ret_commit;
  assign do_push   = !draining && !ret_commit && ret_push && (fill < LW'(VMAX));
  assign last_rd   = (LW'(rd_ptr) + LW'(1)) == len_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      draining <= 1'b0; rd_ptr <= '0; len_q <= '0; fill <= '0;
    end else if (draining) begin
      if (out_read) begin
        if (last_rd) begin
          draining <= 1'b0; rd_ptr <= '0;
        end else rd_ptr <= rd_ptr + PW'(1);
      end
    end else if (do_commit) begin
      len_q <= fill + LW'(3); fill <= '0; draining <= 1'b1;
    end else if (do_push) begin
      fill <= fill + LW'(1);
    end else if (err_ack) begin
      len_q <= LW'(3); draining <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_commit) begin
      buf_q[0] <= ind_hdr(OP_RET, 8'(fill) + 8'd3);
      buf_q[1] <= ret_id;
      buf_q[2] <= ret_proc;
    end else if (do_push) begin
      buf_q[wr_idx] <= ret_word;
    end else if (err_ack) begin
      buf_q[0] <= ind_hdr(OP_ERR, 8'd3);
      buf_q[1] <= err_id;
      buf_q[2] <= err_code;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_read |=> out_valid && $stable(out_data)); // R11
  AST_IND_HDR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (out_data[15:8] == OP_RET) || (out_data[15:8] == OP_ERR)); // R10
  AST_ERR_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) && out_data[15:8] == OP_ERR |-> out_data[7:0] == 8'd3); // R8
endmodule

// File: rtl/hostmsg_decoder.sv
module hostmsg_decoder
  import hostmsg_pkg::*;
#(
  parameter int AW        = 10,
  parameter int MCW       = 16,
  parameter int IND_DEPTH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [15:0]    in_data,
  output logic           in_ready,
  output logic           out_valid,
  output logic [15:0]    out_data,
  input  logic           out_read,
  output logic           ram_we,
  output logic [AW-1:0]  ram_addr,
  output logic [15:0]    ram_wdata,
  output logic [MCW-1:0] mc_cfg,
  output logic [7:0]     cmd_op,
  output logic [15:0]    cmd_id,
  output logic           cmd_word_valid,
  output logic [15:0]    cmd_word,
  output logic           cmd_done,
  input  logic           ret_push,
  input  logic [15:0]    ret_word,
  input  logic           ret_commit,
  input  logic [15:0]    ret_proc,
  input  logic [15:0]    ret_id,
  output logic           ret_ready
);
  logic        err_valid, err_ack;
  logic [15:0] err_id, err_code;

  hostmsg_parser #(.AW(AW), .MCW(MCW)) u_parser (
    .clk, .rst_n, .in_valid, .in_data, .in_ready,
    .ram_we, .ram_addr, .ram_wdata, .mc_cfg,
    .cmd_op, .cmd_id, .cmd_word_valid, .cmd_word, .cmd_done,
    .err_valid, .err_id, .err_code, .err_ack
  );

  hostmsg_ind #(.DEPTH(IND_DEPTH)) u_ind (
    .clk, .rst_n, .ret_push, .ret_word, .ret_commit, .ret_proc, .ret_id,
    .ret_ready, .err_valid, .err_id, .err_code, .err_ack,
    .out_valid, .out_data, .out_read
  );

  AST_ERR_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid && out_valid |=> !in_ready); // R11
endmodule

// File: tb/test_hostmsg_decoder.sv
module test_hostmsg_decoder;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_read = 1'b0, ret_push = 1'b0, ret_commit = 1'b0;
  logic [15:0] in_data = '0, ret_word = '0, ret_proc = '0, ret_id = '0;
  logic in_ready, out_valid, ram_we, cmd_word_valid, cmd_done, ret_ready;
  logic [15:0] out_data, ram_wdata, cmd_id, cmd_word;
  logic [9:0] ram_addr;
  logic [15:0] mc_cfg;
  logic [7:0] cmd_op;
  int n_chk = 0, n_err = 0, we_cnt = 0, cyc = 0;

  always #4 clk = ~clk; // 125 MHz

  hostmsg_decoder i_hostmsg_decoder (.*);

  always @(posedge clk) if (ram_we) we_cnt <= we_cnt + 1;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_err = n_err + 1;
      $display("FAIL watchdog: act=%0d exp<=100000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Word accepted at the next rising edge; outputs sampled at the falling edge after it.
  task automatic send(input logic [15:0] w);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_data = w;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic push(input logic [15:0] w);
    @(negedge clk); ret_push = 1'b1; ret_word = w;
    @(negedge clk); ret_push = 1'b0;
  endtask

  task automatic commit(input logic [15:0] proc, input logic [15:0] id);
    @(negedge clk); ret_commit = 1'b1; ret_proc = proc; ret_id = id;
    @(negedge clk); ret_commit = 1'b0;
  endtask

  task automatic read_ind(input string tag, input int n, input logic [15:0] e0,
                          input logic [15:0] e1, input logic [15:0] e2,
                          input logic [15:0] e3, input logic [15:0] e4);
    logic [15:0] ex [5];
    ex[0] = e0; ex[1] = e1; ex[2] = e2; ex[3] = e3; ex[4] = e4;
    for (int i = 0; i < n; i++) begin
      int t = 0;
      while (!out_valid && t < 20) begin @(negedge clk); t++; end
      chk(tag, {16'd0, out_data}, {16'd0, ex[i]});
      out_read = 1'b1;
      @(negedge clk);
      out_read = 1'b0;
    end
    chk({tag, " drained"}, {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_reset;
    chk("R1 in_ready", {31'd0, in_ready}, 32'd1);
    chk("R1 ret_ready", {31'd0, ret_ready}, 32'd1);
    chk("R1 strobes", {28'd0, out_valid, ram_we, cmd_word_valid, cmd_done}, 32'd0);
    chk("R1 mc_cfg", {16'd0, mc_cfg}, 32'd0);
  endtask

  task automatic t_download;
    send(16'h0077); send(16'hA5A5);
    send(16'h0003);
    chk("R3 mc before", {16'd0, mc_cfg}, 32'h3);
    send(16'd3); send(16'h0100);
    for (int i = 0; i < 3; i++) begin
      send(16'hD000 + 16'(i));
      chk("R4 we", {31'd0, ram_we}, 32'd1);
      chk("R4 addr", {22'd0, ram_addr}, 32'h100 + 32'(i));
      chk("R4 data", {16'd0, ram_wdata}, 32'hD000 + 32'(i));
      chk("R3 mc during data", {16'd0, mc_cfg}, 32'h3);
    end
    send(16'h0001);
    chk("R5 mc after", {16'd0, mc_cfg}, 32'h1);
    chk("R5 no write", {31'd0, ram_we}, 32'd0);
    chk("R4 write count", 32'(we_cnt), 32'd3);
  endtask

  task automatic t_dl_zero;
    int w0 = we_cnt;
    send(16'h0000); send(16'h0001); send(16'h0007);
    chk("R6 mc before", {16'd0, mc_cfg}, 32'h7);
    send(16'd0); send(16'h0005); send(16'h0002);
    chk("R6 mc after", {16'd0, mc_cfg}, 32'h2);
    chk("R6 no writes", 32'(we_cnt - w0), 32'd0);
  endtask

  task automatic t_forward;
    send(16'h0105); send(16'h1234);
    chk("R7 no early done", {31'd0, cmd_done}, 32'd0);
    send(16'h0042);
    chk("R7 word0", {15'd0, cmd_word_valid, cmd_word}, {15'd0, 1'b1, 16'h0042});
    send(16'h00AA);
    chk("R7 word1", {15'd0, cmd_word_valid, cmd_word}, {15'd0, 1'b1, 16'h00AA});
    send(16'h00BB);
    chk("R7 last", {14'd0, cmd_word_valid, cmd_done, cmd_word}, {14'd0, 2'b11, 16'h00BB});
    chk("R2 op/id", {8'd0, cmd_op, cmd_id}, {8'd0, 8'h01, 16'h1234});
    send(16'h0202); send(16'h2222);
    chk("R7 len2 done", {30'd0, cmd_done, cmd_word_valid}, 32'b10);
    chk("R2 pkt op/id", {8'd0, cmd_op, cmd_id}, {8'd0, 8'h02, 16'h2222});
    send(16'h0503); send(16'h3333); send(16'h0009);
    chk("R7 nop", {15'd0, cmd_done, cmd_word}, {15'd0, 1'b1, 16'h0009});
    send(16'h0303); send(16'h4444); send(16'h0001);
    chk("R2 reset op", {24'd0, cmd_op}, 32'h03);
  endtask

  task automatic t_return;
    push(16'h1111); push(16'h2222);
    commit(16'h0042, 16'h1234);
    chk("R10 valid", {31'd0, out_valid}, 32'd1);
    read_ind("R10 ret", 5, 16'h1105, 16'h1234, 16'h0042, 16'h1111, 16'h2222);
  endtask

  task automatic t_errors;
    send(16'h0704); send(16'hBEEF);
    read_ind("R8 bad op", 3, 16'h1203, 16'hBEEF, 16'h0001, 16'h0, 16'h0);
    send(16'h0502); send(16'h0101);
    chk("R8 resync", {15'd0, cmd_done, cmd_id}, {15'd0, 1'b1, 16'h0101});
    send(16'h0102); send(16'h0A0A);
    read_ind("R9 exec short", 3, 16'h1203, 16'h0A0A, 16'h0002, 16'h0, 16'h0);
    send(16'h0302); send(16'h0B0B);
    read_ind("R9 reset short", 3, 16'h1203, 16'h0B0B, 16'h0002, 16'h0, 16'h0);
  endtask

  task automatic t_hold;
    commit(16'h0066, 16'h0055);
    repeat (4) @(negedge clk);
    chk("R11 held", {15'd0, out_valid, out_data}, {15'd0, 1'b1, 16'h1103});
    chk("R11 ret_ready", {31'd0, ret_ready}, 32'd0);
    push(16'h9999);
    send(16'h0904); send(16'h0777);
    repeat (3) @(negedge clk);
    chk("R11 in stall", {31'd0, in_ready}, 32'd0);
    read_ind("R11 first", 3, 16'h1103, 16'h0055, 16'h0066, 16'h0, 16'h0);
    read_ind("R11 queued err", 3, 16'h1203, 16'h0777, 16'h0001, 16'h0, 16'h0);
    commit(16'h0001, 16'h0002);
    read_ind("R11 push ignored", 3, 16'h1103, 16'h0002, 16'h0001, 16'h0, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_download();
    t_dl_zero();
    t_forward();
    t_return();
    t_errors();
    t_hold();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule